// File: doc/BRIEF.md
# Push-Button Power Sequencer

This block is a synchronous controller that brings a processor system up and down from a single push-button and two handshake lines from the processor. A press while the system is dark powers an always-on regulator group first and, after a fixed number of clock cycles, a switchable regulator group. The processor then has to raise its hold line while the button is still down. If the button comes up first, the controller treats the press as accidental and turns everything off.

Once the system is running, the processor is in charge. A button press reaches it as an active-low status output, which it can use as an interrupt. Dropping hold shuts the system down. Dropping the enable line, with the button up, enters a sleep state in which only the always-on group stays powered. Raising enable again, or pressing the button, ends sleep. All outputs are registered. The button input is assumed to be debounced and synchronous already.

Top module: `pb_power_seq`

## Requirements
- R1: While synchronous reset is high, and in the cycle after it, both enable vectors are all zeros and the status output is 1.
- R2: When the system is off and the button input is sampled low, the always-on enable vector goes to all ones in the next cycle while the switchable vector stays all zeros.
- R3: The switchable enable vector goes to all ones exactly STEP_DLY cycles after the always-on vector did, and is never nonzero unless the always-on vector is all ones.
- R4: A button release before power-up finishes (before the cycle after the switchable group turns on), or a release after that with hold still low, turns both enable vectors to all zeros in the next cycle. This applies even if hold was raised early.
- R5: If hold is sampled high after power-up finishes and while the button is still pressed, both groups stay on after the button is released.
- R6: While running or asleep, hold sampled low turns both enable vectors to all zeros in the next cycle.
- R7: While running, enable sampled low with the button released and hold high turns the switchable vector to all zeros in the next cycle and keeps the always-on vector all ones (sleep).
- R8: While asleep with hold high, enable sampled high or the button sampled low turns the switchable vector back to all ones in the next cycle.
- R9: The status output is 1 whenever the system is off. In every other state it equals the button input sampled one cycle earlier.
- R10: While the system is off and the button is released, hold and enable have no effect: both enable vectors stay all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_n | input | 1 | Debounced push-button, active low |
| hold | input | 1 | Processor keep-alive line, active high |
| en | input | 1 | Processor enable for the switchable group, active high |
| aon_en | output | AON_W | Enables of the always-on regulator group |
| sw_en | output | SW_W | Enables of the switchable regulator group |
| btn_stat_n | output | 1 | Button status to the processor, active low |

## Verification
The bench builds the block with STEP_DLY set to 5, with four always-on and eight switchable enables. The short delay lets each power-up be timed to the exact cycle, checking the switchable group one cycle before and at its turn-on edge. It also makes it cheap to abort a boot in each phase: during the delay, while waiting for hold, and with hold raised too early. The sleep tests cover both ways out of sleep, the guard that keeps a held button from re-entering sleep, and the shutdown paths from the running and sleep states.

// File: rtl/pbps_pkg.sv
package pbps_pkg;

  typedef enum logic [2:0] {
    PS_OFF,
    PS_UP_A,
    PS_UP_B,
    PS_WAIT_HOLD,
    PS_ON,
    PS_SLEEP
  } pwr_state_e;

  // Always-on group is powered in every state but off.
  function automatic logic aon_group_on(pwr_state_e s);
    return s != PS_OFF;
  endfunction

  // Switchable group is powered from the second power-up step until sleep/off.
  function automatic logic sw_group_on(pwr_state_e s);
    return (s == PS_UP_B) || (s == PS_WAIT_HOLD) || (s == PS_ON);
  endfunction

  // True on the last cycle of a step delay of dly cycles.
  function automatic logic step_reached(int unsigned cnt, int unsigned dly);
    return (cnt + 1) == dly;
  endfunction

  // States in which the boot can still be aborted by releasing the button.
  function automatic logic in_boot(pwr_state_e s);
    return (s == PS_UP_A) || (s == PS_UP_B) || (s == PS_WAIT_HOLD);
  endfunction

endpackage

// File: rtl/pbps_step_timer.sv
module pbps_step_timer #(
  parameter int STEP_DLY = 16,
  parameter int CNT_W    = $clog2(STEP_DLY + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  import pbps_pkg::*;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end

  assign done = run && step_reached(32'(cnt_q), STEP_DLY);

endmodule

// File: rtl/pbps_fsm.sv
module pbps_fsm (
  input  pbps_pkg::pwr_state_e st_q,
  input  logic                 btn_n,
  input  logic                 hold,
  input  logic                 en,
  input  logic                 step_done,
  output pbps_pkg::pwr_state_e st_nxt,
  output logic                 boot_abort
);
  import pbps_pkg::*;

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      PS_OFF:       if (!btn_n) st_nxt = PS_UP_A;
      PS_UP_A: begin
        if (btn_n)          st_nxt = PS_OFF;
        else if (step_done) st_nxt = PS_UP_B;
      end
      PS_UP_B:      st_nxt = btn_n ? PS_OFF : PS_WAIT_HOLD;
      PS_WAIT_HOLD: begin
        if (hold)       st_nxt = PS_ON;
        else if (btn_n) st_nxt = PS_OFF;
      end
      PS_ON: begin
        if (!hold)            st_nxt = PS_OFF;
        else if (!en && btn_n) st_nxt = PS_SLEEP;
      end
      PS_SLEEP: begin
        if (!hold)           st_nxt = PS_OFF;
        else if (en || !btn_n) st_nxt = PS_ON;
      end
      default:      st_nxt = PS_OFF;
    endcase
  end

  assign boot_abort = in_boot(st_q) && (st_nxt == PS_OFF);

endmodule

// File: rtl/pbps_outreg.sv
module pbps_outreg #(
  parameter int AON_W = 4,
  parameter int SW_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  pbps_pkg::pwr_state_e st_nxt,
  input  logic                 btn_n,
  output logic [AON_W-1:0]     aon_en,
  output logic [SW_W-1:0]      sw_en,
  output logic                 btn_stat_n
);
  import pbps_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      aon_en     <= '0;
      sw_en      <= '0;
      btn_stat_n <= 1'b1;
    end else begin
      aon_en     <= {AON_W{aon_group_on(st_nxt)}};
      sw_en      <= {SW_W{sw_group_on(st_nxt)}};
      btn_stat_n <= (st_nxt == PS_OFF) ? 1'b1 : btn_n;
    end
  end

endmodule

// File: rtl/pb_power_seq.sv
module pb_power_seq #(
  parameter int AON_W    = 4,
  parameter int SW_W     = 8,
  parameter int STEP_DLY = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btn_n,
  input  logic             hold,
  input  logic             en,
  output logic [AON_W-1:0] aon_en,
  output logic [SW_W-1:0]  sw_en,
  output logic             btn_stat_n
);
  import pbps_pkg::*;

  localparam int CNT_W = $clog2(STEP_DLY + 1);

  pwr_state_e st_q;
  pwr_state_e st_nxt;
  logic       step_done;
  logic       boot_abort;

  always_ff @(posedge clk) begin
    if (rst) st_q <= PS_OFF;
    else     st_q <= st_nxt;
  end

  pbps_step_timer #(
    .STEP_DLY(STEP_DLY),
    .CNT_W   (CNT_W)
  ) u_timer (
    .clk (clk),
    .rst (rst),
    .run (st_q == PS_UP_A),
    .done(step_done)
  );

  pbps_fsm u_fsm (
    .st_q      (st_q),
    .btn_n     (btn_n),
    .hold      (hold),
    .en        (en),
    .step_done (step_done),
    .st_nxt    (st_nxt),
    .boot_abort(boot_abort)
  );

  pbps_outreg #(
    .AON_W(AON_W),
    .SW_W (SW_W)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .st_nxt    (st_nxt),
    .btn_n     (btn_n),
    .aon_en    (aon_en),
    .sw_en     (sw_en),
    .btn_stat_n(btn_stat_n)
  );

endmodule

// File: rtl/pbps_checker.sv
module pbps_checker #(
  parameter int AON_W = 4,
  parameter int SW_W  = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 btn_n,
  input logic                 hold,
  input logic                 en,
  input logic [AON_W-1:0]     aon_en,
  input logic [SW_W-1:0]      sw_en,
  input logic                 btn_stat_n,
  input pbps_pkg::pwr_state_e st_q,
  input logic                 boot_abort
);
  import pbps_pkg::*;

  AST_RESET_DARK: assert property (@(posedge clk)
    rst |=> (aon_en == '0) && (sw_en == '0) && btn_stat_n); // R1

  AST_PRESS_AON: assert property (@(posedge clk) disable iff (rst)
    (st_q == PS_OFF) && !btn_n |=> (&aon_en) && (sw_en == '0)); // R2

  AST_SW_NEEDS_AON: assert property (@(posedge clk) disable iff (rst)
    (sw_en != '0) |-> (&aon_en)); // R3

  AST_ABORT_DARK: assert property (@(posedge clk) disable iff (rst)
    boot_abort |=> (aon_en == '0) && (sw_en == '0)); // R4

  AST_HOLD_TAKEOVER: assert property (@(posedge clk) disable iff (rst)
    (st_q == PS_WAIT_HOLD) && hold |=> (&aon_en) && (&sw_en)); // R5

  AST_HOLD_DROP: assert property (@(posedge clk) disable iff (rst)
    ((st_q == PS_ON) || (st_q == PS_SLEEP)) && !hold |=> (aon_en == '0) && (sw_en == '0)); // R6

  AST_SLEEP_SPLIT: assert property (@(posedge clk) disable iff (rst)
    (st_q == PS_ON) && hold && !en && btn_n |=> (sw_en == '0) && (&aon_en)); // R7

  AST_WAKE: assert property (@(posedge clk) disable iff (rst)
    (st_q == PS_SLEEP) && hold && (en || !btn_n) |=> (&sw_en) && (&aon_en)); // R8

  AST_STAT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st_q == PS_OFF) |-> btn_stat_n); // R9

  AST_STAT_TRACK: assert property (@(posedge clk) disable iff (rst)
    (st_q != PS_OFF) |-> (btn_stat_n == $past(btn_n))); // R9

  AST_OFF_IGNORES: assert property (@(posedge clk) disable iff (rst)
    (st_q == PS_OFF) && btn_n |=> (aon_en == '0) && (sw_en == '0)); // R10

endmodule

bind pb_power_seq pbps_checker #(
  .AON_W(AON_W),
  .SW_W (SW_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .btn_n     (btn_n),
  .hold      (hold),
  .en        (en),
  .aon_en    (aon_en),
  .sw_en     (sw_en),
  .btn_stat_n(btn_stat_n),
  .st_q      (st_q),
  .boot_abort(boot_abort)
);

// File: tb/pb_power_seq_tb.sv
`timescale 1ns/1ps
module pb_power_seq_tb;
  localparam int AON_W = 4;
  localparam int SW_W  = 8;
  localparam int STEP  = 5;
  localparam logic [31:0] AON_ALL = (32'd1 << AON_W) - 32'd1;
  localparam logic [31:0] SW_ALL  = (32'd1 << SW_W) - 32'd1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_n = 1'b1;
  logic hold = 1'b0;
  logic en = 1'b0;
  logic [AON_W-1:0] aon_en;
  logic [SW_W-1:0]  sw_en;
  logic             btn_stat_n;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pb_power_seq #(.AON_W(AON_W), .SW_W(SW_W), .STEP_DLY(STEP)) u_dut (
    .clk(clk), .rst(rst), .btn_n(btn_n), .hold(hold), .en(en),
    .aon_en(aon_en), .sw_en(sw_en), .btn_stat_n(btn_stat_n)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; btn_n = 1'b1; hold = 1'b0; en = 1'b0;
    tick(3);
    chk("R1 aon in reset", 32'(aon_en), 0);
    chk("R1 sw in reset", 32'(sw_en), 0);
    chk("R1 stat in reset", 32'(btn_stat_n), 1);
    rst = 1'b0;
    tick(1);
    chk("R1 aon after reset", 32'(aon_en), 0);
  endtask

  // Full boot: leaves the system running with hold and en high, button up.
  task automatic boot_ok();
    en = 1'b1; btn_n = 1'b0;
    tick(1);
    chk("R2 aon on press", 32'(aon_en), AON_ALL);
    chk("R2 sw off on press", 32'(sw_en), 0);
    tick(STEP - 1);
    chk("R3 sw before delay", 32'(sw_en), 0);
    tick(1);
    chk("R3 sw at delay", 32'(sw_en), SW_ALL);
    hold = 1'b1;
    tick(3);
    btn_n = 1'b1;
    tick(2);
    chk("R5 aon after release", 32'(aon_en), AON_ALL);
    chk("R5 sw after release", 32'(sw_en), SW_ALL);
  endtask

  task automatic t_off_ignores();
    do_reset();
    hold = 1'b1; en = 1'b1;
    tick(4);
    chk("R10 aon with hold/en", 32'(aon_en), 0);
    chk("R10 sw with hold/en", 32'(sw_en), 0);
    chk("R9 stat while off", 32'(btn_stat_n), 1);
    en = 1'b0;
    tick(2);
    chk("R10 aon hold only", 32'(aon_en), 0);
    hold = 1'b0;
  endtask

  task automatic t_abort_early();
    do_reset();
    en = 1'b1; hold = 1'b1; btn_n = 1'b0;
    tick(2);
    chk("R9 stat during boot", 32'(btn_stat_n), 0);
    btn_n = 1'b1;
    tick(1);
    chk("R4 aon after early release", 32'(aon_en), 0);
    chk("R4 sw after early release", 32'(sw_en), 0);
    chk("R9 stat after abort", 32'(btn_stat_n), 1);
    hold = 1'b0;
  endtask

  task automatic t_abort_wait();
    do_reset();
    en = 1'b1; btn_n = 1'b0;
    tick(1 + STEP);
    chk("R3 sw on in abort run", 32'(sw_en), SW_ALL);
    tick(3);
    chk("R4 still waiting for hold", 32'(sw_en), SW_ALL);
    btn_n = 1'b1;
    tick(1);
    chk("R4 aon after release without hold", 32'(aon_en), 0);
    chk("R4 sw after release without hold", 32'(sw_en), 0);
  endtask

  task automatic t_status_and_off();
    do_reset();
    boot_ok();
    chk("R9 stat idle when on", 32'(btn_stat_n), 1);
    btn_n = 1'b0;
    tick(1);
    chk("R9 stat on press", 32'(btn_stat_n), 0);
    chk("R9 press keeps sw on", 32'(sw_en), SW_ALL);
    btn_n = 1'b1;
    tick(1);
    chk("R9 stat on release", 32'(btn_stat_n), 1);
    hold = 1'b0;
    tick(1);
    chk("R6 aon after hold drop", 32'(aon_en), 0);
    chk("R6 sw after hold drop", 32'(sw_en), 0);
  endtask

  task automatic t_sleep();
    do_reset();
    boot_ok();
    en = 1'b0;
    tick(1);
    chk("R7 sw in sleep", 32'(sw_en), 0);
    chk("R7 aon in sleep", 32'(aon_en), AON_ALL);
    tick(3);
    chk("R7 sleep persists", 32'(sw_en), 0);
    en = 1'b1;
    tick(1);
    chk("R8 wake by enable", 32'(sw_en), SW_ALL);
    en = 1'b0;
    tick(1);
    chk("R7 sleep again", 32'(sw_en), 0);
    btn_n = 1'b0;
    tick(1);
    chk("R8 wake by button", 32'(sw_en), SW_ALL);
    chk("R9 stat in wake", 32'(btn_stat_n), 0);
    tick(2);
    chk("R7 no sleep while pressed", 32'(sw_en), SW_ALL);
    btn_n = 1'b1;
    tick(1);
    chk("R7 sleep after release", 32'(sw_en), 0);
    hold = 1'b0;
    tick(1);
    chk("R6 aon off from sleep", 32'(aon_en), 0);
  endtask

  initial begin
    t_off_ignores();
    t_abort_early();
    t_abort_wait();
    t_status_and_off();
    t_sleep();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule